// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block accepts 22-bit configuration words for a two-channel frequency synthesizer over a three-wire serial link made of a data line, a serial clock and a load strobe. All three wires are synchronized into the system clock domain. A rising serial clock shifts the current data bit into a 22-bit shift register, most significant bit first. A rising load strobe commits the register to one of four configuration latches. The last two bits of each word form an address that picks the latch: a reference/mode latch or a feedback-divider latch, for either channel.

The latched fields are presented as outputs to the divider, phase-detector and charge-pump datapaths, which sit outside this block. Two of the mode bits in each reference latch also drive a monitor output multiplexer. That multiplexer shows lock status or one divider output, or it issues a counter-reset request.

Commits are sequenced by a three-state load controller. The states are:
- `LD_IDLE`: waiting for a strobe.
- `LD_COMMIT`: writes exactly one latch for one cycle.
- `LD_WAIT_LOW`: the strobe is still high.

The transitions are:
- A synchronized strobe rising edge moves `LD_IDLE` to `LD_COMMIT` and snapshots the shift register.
- `LD_COMMIT` moves to `LD_WAIT_LOW` if the strobe is still high, otherwise to `LD_IDLE`.
- `LD_WAIT_LOW` returns to `LD_IDLE` once the strobe is low.

Top module: `synth_cfg_loader`

## Requirements
- R1: Each synchronized rising edge of `ser_clk` shifts the synchronized `ser_data` bit into the shift register, most significant bit first. In a 22-bit word, the last two bits shifted are the address: the first of them is address bit 1 and the last is address bit 0. The 20 bits before them are payload bits P20 (shifted first) down to P1.
- R2: Address 00 writes the channel-1 reference latch, 01 the channel-2 reference latch, 10 the channel-1 feedback latch and 11 the channel-2 feedback latch. All other latches keep their values.
- R3: A reference word holds the following fields:
  - P1..P15: divide ratio, with P15 as its MSB.
  - P16: detector polarity.
  - P17: pump current select.
  - P18: pump high-Z.
  - P19: lock-monitor select.
  - P20: divider-monitor select.
- R4: A feedback word holds the following fields:
  - P1..P7: swallow count A, with P7 as its MSB.
  - P8..P18: main count B, with P18 as its MSB.
  - P19: prescaler select.
  - P20: powerdown.
- R5: For channel 1, only P1..P4 of the swallow count are kept. Bits 6:4 of channel 1's A output always read 0.
- R6: Latches change only on a rising edge of the load strobe. Shifting with the strobe low or held high has no effect on the outputs, and a strobe that stays high commits only once.
- R7: A latch still loads while either channel has its powerdown bit set.
- R8: After reset, every latched field is 0, `mon_out` is 0 and `cnt_reset` is 0.
- R9: With both divider-monitor bits at 0, `mon_out` depends on the two lock-monitor bits (channel 2, channel 1):
  - 00: low.
  - 01: channel-1 lock.
  - 10: channel-2 lock.
  - 11: the AND of both locks.
- R10: With exactly one divider-monitor bit set, `mon_out` shows that channel's divider. The channel-1 lock-monitor bit picks reference (0) or feedback (1).
- R11: With all four monitor bits set, `cnt_reset` is 1 and `mon_out` is low. Any other combination with both divider-monitor bits set drives `mon_out` low with `cnt_reset` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, commits on rising edge |
| lock_in | input | 2 | Per-channel lock indication (bit 0 = channel 1) |
| refdiv_in | input | 2 | Per-channel reference divider output |
| fbdiv_in | input | 2 | Per-channel feedback divider output |
| rdiv_ratio | output | 2x15 | Reference divide ratio per channel |
| pd_polarity | output | 2 | Detector polarity per channel |
| pump_cur | output | 2 | Pump current select per channel |
| pump_hiz | output | 2 | Pump high-Z per channel |
| a_count | output | 2x7 | Swallow count per channel |
| b_count | output | 2x11 | Main count per channel |
| presc_sel | output | 2 | Prescaler select per channel |
| pwr_down | output | 2 | Powerdown per channel |
| mon_out | output | 1 | Multiplexed monitor output |
| cnt_reset | output | 1 | Counter-reset request to all dividers |

## Verification
The bench loads each of the four addresses in turn and confirms that the untouched latches hold their values. A swapped address decode would corrupt the wrong channel. It shifts a full word while the strobe is low, and another while the strobe is held high, before committing. A level-triggered or retriggering load would change the outputs early. It loads channel 1 with a swallow count of 127 and expects 15, which catches an unmasked upper field. It walks every monitor-select combination, including the reserved ones and the all-ones reset. A mis-ordered select would show the wrong channel, or would raise the reset with the monitor still active.

// File: rtl/slcfg_pkg.sv
package slcfg_pkg;
    localparam int WORD_W = 22;
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;
    localparam int RDIV_W = 15;
    localparam int A_W    = 7;
    localparam int B_W    = 11;
    localparam int N_LATCH = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_REF_CH1 = 2'b00,
        ADR_REF_CH2 = 2'b01,
        ADR_FB_CH1  = 2'b10,
        ADR_FB_CH2  = 2'b11
    } addr_e;

    typedef struct packed {
        logic              div_mon;
        logic              lock_mon;
        logic              hiz;
        logic              pump_cur;
        logic              polarity;
        logic [RDIV_W-1:0] ratio;
    } ref_word_t;

    typedef struct packed {
        logic           pwr_dn;
        logic           presc;
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } fb_word_t;

    typedef enum logic [1:0] {
        LD_IDLE     = 2'd0,
        LD_COMMIT   = 2'd1,
        LD_WAIT_LOW = 2'd2
    } ld_state_e;
endpackage

// File: rtl/serial_front.sv
module serial_front
    import slcfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic              le_level,
    output logic              le_rise,
    output logic [WORD_W-1:0] shift_q
);
    logic [STAGES-1:0] s_clk, s_dat, s_le;
    logic              clk_prev, le_prev;
    logic              clk_rise;
    logic              dat_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_clk    <= '0;
            s_dat    <= '0;
            s_le     <= '0;
            clk_prev <= 1'b0;
            le_prev  <= 1'b0;
        end else begin
            s_clk    <= {s_clk[STAGES-2:0], ser_clk};
            s_dat    <= {s_dat[STAGES-2:0], ser_data};
            s_le     <= {s_le[STAGES-2:0], ser_le};
            clk_prev <= s_clk[STAGES-1];
            le_prev  <= s_le[STAGES-1];
        end
    end

    assign clk_rise = s_clk[STAGES-1] & ~clk_prev;
    assign dat_bit  = s_dat[STAGES-1];
    assign le_level = s_le[STAGES-1];
    assign le_rise  = s_le[STAGES-1] & ~le_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (clk_rise) begin
            shift_q <= {shift_q[WORD_W-2:0], dat_bit};
        end
    end

    // R1: a detected serial edge shifts left by one, new bit at the bottom
    a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rise |=> (shift_q[0] == $past(dat_bit)) &&
                     (shift_q[WORD_W-1:1] == $past(shift_q[WORD_W-2:0])));

    // R6: without a serial edge the register holds
    a_r6_hold_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_rise |=> $stable(shift_q));
endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
    import slcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               le_level,
    input  logic               le_rise,
    input  logic [WORD_W-1:0]  shift_q,
    output logic [N_LATCH-1:0] wr_en,
    output logic [PAY_W-1:0]   payload
);
    ld_state_e         state, state_nx;
    logic [WORD_W-1:0] snap_q;
    addr_e             adr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (state == LD_IDLE && le_rise) begin
            snap_q <= shift_q;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_IDLE:     if (le_rise)   state_nx = LD_COMMIT;
            LD_COMMIT:   state_nx = le_level ? LD_WAIT_LOW : LD_IDLE;
            LD_WAIT_LOW: if (!le_level) state_nx = LD_IDLE;
            default:     state_nx = LD_IDLE;
        endcase
    end

    assign adr     = addr_e'(snap_q[ADDR_W-1:0]);
    assign payload = snap_q[WORD_W-1:ADDR_W];

    always_comb begin
        wr_en = '0;
        unique case (state)
            LD_COMMIT: wr_en[adr] = 1'b1;
            LD_IDLE, LD_WAIT_LOW: wr_en = '0;
            default: wr_en = '0;
        endcase
    end

    // R2: at most one latch is written per cycle
    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R6: a commit lasts exactly one cycle
    a_r6_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LD_COMMIT) |=> (state != LD_COMMIT));
endmodule

// File: rtl/cfg_latches.sv
module cfg_latches
    import slcfg_pkg::*;
#(
    parameter int CH1_A_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LATCH-1:0] wr_en,
    input  logic [PAY_W-1:0]   payload,
    output ref_word_t [1:0]    ref_q,
    output fb_word_t  [1:0]    fb_q
);
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        fb_word_t fb_in;

        if (ch == 0) begin : g_mask
            always_comb begin
                fb_in   = fb_word_t'(payload);
                fb_in.a = A_W'(payload[CH1_A_BITS-1:0]);
            end
            // R5: channel 1 swallow count never holds upper bits
            a_r5_ch1_a_upper: assert property (@(posedge clk) disable iff (!rst_n)
                fb_q[0].a[A_W-1:CH1_A_BITS] == '0);
        end else begin : g_full
            assign fb_in = fb_word_t'(payload);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ref_q[ch] <= '0;
            end else if (wr_en[ch]) begin
                ref_q[ch] <= ref_word_t'(payload);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fb_q[ch] <= '0;
            end else if (wr_en[2+ch]) begin
                fb_q[ch] <= fb_in;
            end
        end

        // R2/R6: a latch moves only when its own write strobe was raised
        a_r2_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[ch] |=> $stable(ref_q[ch]));
        a_r2_fb_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[2+ch] |=> $stable(fb_q[ch]));
    end
endmodule

// File: rtl/mon_mux.sv
module mon_mux (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lock_mon,
    input  logic [1:0] div_mon,
    input  logic [1:0] lock_in,
    input  logic [1:0] refdiv_in,
    input  logic [1:0] fbdiv_in,
    output logic       mon_out,
    output logic       cnt_reset
);
    logic [3:0] sel;
    assign sel = {div_mon[1], div_mon[0], lock_mon[1], lock_mon[0]};

    always_comb begin
        mon_out   = 1'b0;
        cnt_reset = 1'b0;
        unique casez (sel)
            4'b0000: mon_out = 1'b0;
            4'b0001: mon_out = lock_in[0];
            4'b0010: mon_out = lock_in[1];
            4'b0011: mon_out = lock_in[0] & lock_in[1];
            4'b01?0: mon_out = refdiv_in[0];
            4'b01?1: mon_out = fbdiv_in[0];
            4'b10?0: mon_out = refdiv_in[1];
            4'b10?1: mon_out = fbdiv_in[1];
            4'b1111: cnt_reset = 1'b1;
            default: mon_out = 1'b0;
        endcase
    end

    // R11: reset request never coexists with an active monitor
    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reset |-> !mon_out);
    // R9: both selects off keeps the monitor low
    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mon == 2'b00 && div_mon == 2'b00) |-> !mon_out);
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import slcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CH1_A_BITS  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk,
    input  logic                   ser_data,
    input  logic                   ser_le,
    input  logic [1:0]             lock_in,
    input  logic [1:0]             refdiv_in,
    input  logic [1:0]             fbdiv_in,
    output logic [1:0][RDIV_W-1:0] rdiv_ratio,
    output logic [1:0]             pd_polarity,
    output logic [1:0]             pump_cur,
    output logic [1:0]             pump_hiz,
    output logic [1:0][A_W-1:0]    a_count,
    output logic [1:0][B_W-1:0]    b_count,
    output logic [1:0]             presc_sel,
    output logic [1:0]             pwr_down,
    output logic                   mon_out,
    output logic                   cnt_reset
);
    logic               le_level, le_rise;
    logic [WORD_W-1:0]  shift_q;
    logic [N_LATCH-1:0] wr_en;
    logic [PAY_W-1:0]   payload;
    ref_word_t [1:0]    ref_q;
    fb_word_t  [1:0]    fb_q;
    logic [1:0]         lock_mon, div_mon;

    serial_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .le_level(le_level), .le_rise(le_rise),
        .shift_q(shift_q)
    );

    load_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .le_level(le_level), .le_rise(le_rise),
        .shift_q(shift_q), .wr_en(wr_en), .payload(payload)
    );

    cfg_latches #(.CH1_A_BITS(CH1_A_BITS)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .payload(payload),
        .ref_q(ref_q), .fb_q(fb_q)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_out
        assign rdiv_ratio[ch]  = ref_q[ch].ratio;
        assign pd_polarity[ch] = ref_q[ch].polarity;
        assign pump_cur[ch]    = ref_q[ch].pump_cur;
        assign pump_hiz[ch]    = ref_q[ch].hiz;
        assign lock_mon[ch]    = ref_q[ch].lock_mon;
        assign div_mon[ch]     = ref_q[ch].div_mon;
        assign a_count[ch]     = fb_q[ch].a;
        assign b_count[ch]     = fb_q[ch].b;
        assign presc_sel[ch]   = fb_q[ch].presc;
        assign pwr_down[ch]    = fb_q[ch].pwr_dn;
    end

    mon_mux u_mon (
        .clk(clk), .rst_n(rst_n), .lock_mon(lock_mon), .div_mon(div_mon),
        .lock_in(lock_in), .refdiv_in(refdiv_in), .fbdiv_in(fbdiv_in),
        .mon_out(mon_out), .cnt_reset(cnt_reset)
    );
endmodule

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [1:0] lock_in = '0, refdiv_in = '0, fbdiv_in = '0;
    logic [1:0][14:0] rdiv_ratio;
    logic [1:0] pd_polarity, pump_cur, pump_hiz, presc_sel, pwr_down;
    logic [1:0][6:0] a_count;
    logic [1:0][10:0] b_count;
    logic mon_out, cnt_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    synth_cfg_loader u_synth_cfg_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .lock_in(lock_in), .refdiv_in(refdiv_in),
        .fbdiv_in(fbdiv_in), .rdiv_ratio(rdiv_ratio), .pd_polarity(pd_polarity),
        .pump_cur(pump_cur), .pump_hiz(pump_hiz), .a_count(a_count),
        .b_count(b_count), .presc_sel(presc_sel), .pwr_down(pwr_down),
        .mon_out(mon_out), .cnt_reset(cnt_reset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [19:0] pay, input logic [1:0] adr);
        logic [21:0] w;
        w = {pay, adr};
        for (int i = 21; i >= 0; i--) begin
            ser_data = w[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        repeat (6) @(negedge clk);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input logic [19:0] pay, input logic [1:0] adr);
        shift_word(pay, adr);
        pulse_le();
    endtask

    function automatic logic [19:0] rpay(input logic [14:0] ratio, input logic pol,
        input logic cpi, input logic hiz, input logic ldm, input logic fom);
        return {fom, ldm, hiz, cpi, pol, ratio};
    endfunction

    function automatic logic [19:0] npay(input logic [6:0] a, input logic [10:0] b,
        input logic pre, input logic pd);
        return {pd, pre, b, a};
    endfunction

    task automatic set_mon(input logic ld1, input logic ld2, input logic fo1, input logic fo2);
        send(rpay(15'd100, 1'b0, 1'b0, 1'b0, ld1, fo1), 2'b00);
        send(rpay(15'd200, 1'b0, 1'b0, 1'b0, ld2, fo2), 2'b01);
    endtask

    task automatic t_reset();
        check("R8 ratio", rdiv_ratio, '0);
        check("R8 a", a_count, '0);
        check("R8 b", b_count, '0);
        check("R8 bits", {pd_polarity, pump_cur, pump_hiz, presc_sel, pwr_down}, '0);
        check("R8 mon", {mon_out, cnt_reset}, 2'b00);
    endtask

    task automatic t_ref_words();
        send(rpay(15'h5A3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0), 2'b00);
        check("R3 ch1 ratio", rdiv_ratio[0], 15'h5A3C);
        check("R3 ch1 pol/cur/hiz", {pd_polarity[0], pump_cur[0], pump_hiz[0]}, 3'b101);
        check("R2 ch2 ref untouched", rdiv_ratio[1], 15'd0);
        check("R2 fb untouched", {a_count, b_count}, '0);
        send(rpay(15'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 2'b01);
        check("R3 ch2 ratio", rdiv_ratio[1], 15'd3);
        check("R3 ch2 pol/cur/hiz", {pd_polarity[1], pump_cur[1], pump_hiz[1]}, 3'b010);
        check("R2 ch1 ref kept", rdiv_ratio[0], 15'h5A3C);
    endtask

    task automatic t_fb_words();
        send(npay(7'h55, 11'h4D3, 1'b1, 1'b0), 2'b11);
        check("R4 ch2 a", a_count[1], 7'h55);
        check("R4 ch2 b", b_count[1], 11'h4D3);
        check("R4 ch2 presc/pd", {presc_sel[1], pwr_down[1]}, 2'b10);
        check("R2 ch1 fb untouched", {a_count[0], b_count[0]}, '0);
        send(npay(7'h7F, 11'd3, 1'b0, 1'b0), 2'b10);
        check("R5 ch1 a masked", a_count[0], 7'h0F);
        check("R4 ch1 b", b_count[0], 11'd3);
        check("R2 ch2 fb kept", b_count[1], 11'h4D3);
        check("R2 ref kept", rdiv_ratio[1], 15'd3);
    endtask

    task automatic t_no_le();
        shift_word(rpay(15'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 2'b00);
        repeat (10) @(negedge clk);
        check("R6 no strobe no change", rdiv_ratio[0], 15'h5A3C);
        pulse_le();
        check("R6 strobe commits", rdiv_ratio[0], 15'h1234);
    endtask

    task automatic t_le_held();
        ser_le = 1'b1;
        repeat (6) @(negedge clk);
        check("R6 held strobe commits current", rdiv_ratio[0], 15'h1234);
        shift_word(rpay(15'h0777, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 2'b00);
        repeat (6) @(negedge clk);
        check("R6 held strobe no reload", rdiv_ratio[0], 15'h1234);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 falling strobe no load", rdiv_ratio[0], 15'h1234);
        pulse_le();
        check("R6 next rise loads", rdiv_ratio[0], 15'h0777);
    endtask

    task automatic t_powerdown();
        send(npay(7'h03, 11'd10, 1'b0, 1'b1), 2'b10);
        check("R4 ch1 pd set", pwr_down[0], 1'b1);
        send(npay(7'h09, 11'd20, 1'b1, 1'b1), 2'b11);
        check("R7 ch2 load while pd", {pwr_down[1], b_count[1]}, {1'b1, 11'd20});
        send(rpay(15'h2222, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0), 2'b00);
        check("R7 ref load while pd", rdiv_ratio[0], 15'h2222);
        send(npay(7'h03, 11'd10, 1'b0, 1'b0), 2'b10);
        check("R7 powerup load", pwr_down[0], 1'b0);
    endtask

    task automatic t_mon_lock();
        set_mon(1'b0, 1'b0, 1'b0, 1'b0);
        lock_in = 2'b11; @(negedge clk);
        check("R9 off low", mon_out, 1'b0);
        set_mon(1'b1, 1'b0, 1'b0, 1'b0);
        lock_in = 2'b01; @(negedge clk);
        check("R9 ch1 lock hi", mon_out, 1'b1);
        lock_in = 2'b10; @(negedge clk);
        check("R9 ch1 lock lo", mon_out, 1'b0);
        set_mon(1'b0, 1'b1, 1'b0, 1'b0);
        check("R9 ch2 lock", mon_out, 1'b1);
        set_mon(1'b1, 1'b1, 1'b0, 1'b0);
        check("R9 both one locked", mon_out, 1'b0);
        lock_in = 2'b11; @(negedge clk);
        check("R9 both locked", mon_out, 1'b1);
        lock_in = 2'b00;
    endtask

    task automatic t_mon_div();
        set_mon(1'b0, 1'b0, 1'b1, 1'b0);
        refdiv_in = 2'b01; fbdiv_in = 2'b00; @(negedge clk);
        check("R10 ch1 ref", mon_out, 1'b1);
        refdiv_in = 2'b10; @(negedge clk);
        check("R10 ch1 ref low", mon_out, 1'b0);
        set_mon(1'b1, 1'b0, 1'b1, 1'b0);
        refdiv_in = 2'b00; fbdiv_in = 2'b01; @(negedge clk);
        check("R10 ch1 fb", mon_out, 1'b1);
        set_mon(1'b0, 1'b0, 1'b0, 1'b1);
        refdiv_in = 2'b10; fbdiv_in = 2'b01; @(negedge clk);
        check("R10 ch2 ref", mon_out, 1'b1);
        set_mon(1'b1, 1'b0, 1'b0, 1'b1);
        check("R10 ch2 fb low", mon_out, 1'b0);
        fbdiv_in = 2'b10; @(negedge clk);
        check("R10 ch2 fb", mon_out, 1'b1);
    endtask

    task automatic t_cnt_reset();
        refdiv_in = 2'b11; fbdiv_in = 2'b11; lock_in = 2'b11;
        set_mon(1'b1, 1'b1, 1'b1, 1'b1);
        check("R11 reset request", {cnt_reset, mon_out}, 2'b10);
        set_mon(1'b1, 1'b0, 1'b1, 1'b1);
        check("R11 reserved quiet", {cnt_reset, mon_out}, 2'b00);
        set_mon(1'b0, 1'b0, 1'b1, 1'b1);
        check("R11 reserved quiet 2", {cnt_reset, mon_out}, 2'b00);
        set_mon(1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 reset released", cnt_reset, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_ref_words();
        t_fb_words();
        t_no_le();
        t_le_held();
        t_powerdown();
        t_mon_lock();
        t_mon_div();
        t_cnt_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule